// File: doc/BRIEF.md
# Configurable Dataflow Overlay Tile

This block is a single tile of a coarse-grain overlay onto which a data flow graph is mapped at run time. It contains one full-word integer functional unit (FU) and a four-port switch that links it to its north, east, south and west neighbours. A configuration word, shifted in one bit per cycle, selects the FU operation, the source of each FU operand, and the source of each output port. An output can take its word from another input (a pass-through link), from the FU result, or from a programmed constant. It can also be left unused.

Every link carries a data word with a valid from the producer and a ready from the consumer. A graph spread over many tiles therefore runs as an elastic pipeline, and a new operand set can enter a tile while earlier results are still waiting downstream. Each output port holds a two-entry skid buffer. Its upstream ready depends only on registered state, so the ready paths in an array of tiles do not chain combinationally.

Top module: `overlay_tile`

## Requirements
- R1: After reset, every output valid and every input ready is low, and every source select is "none".
- R2: The FU computes the operation given by the 3-bit code: 0 add, 1 subtract, 2 multiply (lower DATA_W bits kept), 3 shift left by the low log2(DATA_W) bits of B, 4 logical shift right by the same amount, 5 signed less-than (1 or 0), 6 bitwise AND, 7 pass A.
- R3: The FU fires only when both selected operands are valid and every output that selects the FU can accept a word. When it fires, it takes both operands in the same cycle.
- R4: An output whose select names an input (0 N, 1 E, 2 S, 3 W) forwards that input's words, and the FU is not involved. A word accepted at one edge is valid at the output from that edge on.
- R5: An output whose select is 5 presents the constant field, valid whenever its buffer has room.
- R6: While an output is valid and its ready is low, its data and valid stay unchanged, unless a configuration load is in progress.
- R7: Each output buffers two words. With its ready held low, it accepts two words, then drops the upstream ready, and later delivers both words in order.
- R8: While the configuration enable is high, all output valids and input readies are low, and the output buffers are emptied.
- R9: An output with select 6 or 7 never asserts valid. An input that no sink selects never asserts ready.
- R10: When one input feeds several sinks, a word transfers only when all of those sinks can accept it, and it then reaches each of them.
- R11: Configuration bits enter LSB first while the enable is high. After DATA_W+21 bits, the word is laid out from bit 0 upward as: operation[2:0], operand A select[5:3], operand B select[8:6], output N, E, S, W selects (3 bits each, from bit 9), then the constant in the top DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_bit_i | input | 1 | Serial configuration bit |
| in_data_i | input | 4 x DATA_W | Data from N, E, S, W (index 0..3) |
| in_valid_i | input | 4 | Valid per input |
| in_ready_o | output | 4 | Ready per input |
| out_data_o | output | 4 x DATA_W | Data toward N, E, S, W |
| out_valid_o | output | 4 | Valid per output |
| out_ready_i | input | 4 | Ready per output |

## Verification
The operation table covers carry wrap on add, borrow on subtract, truncation of the product, a shift amount wider than the index bits, and signed compare of negative against positive. An FU that ignored any one of these would return the untruncated or unsigned value. Directed tests hold back one operand and check that the other input is not consumed early, since a faulty join would drop or duplicate operands. The skid test stalls an output for three offered words and checks that the third is refused and the first two come out in order; a buffer that lost a word or swapped them would fail there. The fork test stalls one of two sinks and checks that the shared input stops for both, which catches a design that lets a word reach one sink and not the other.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int unsigned NPORT = 4;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned OP_W  = 3;
  localparam int unsigned CTRL_W = OP_W + 2*SEL_W + NPORT*SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_N = 3'd0, SRC_E = 3'd1, SRC_S = 3'd2, SRC_W = 3'd3,
    SRC_FU = 3'd4, SRC_K = 3'd5, SRC_NONE = 3'd6, SRC_OFF = 3'd7
  } src_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_SHL = 3'd3,
    OP_SRL = 3'd4, OP_SLT = 3'd5, OP_AND = 3'd6, OP_PASS = 3'd7
  } op_e;
endpackage

// File: rtl/tile_cfg_chain.sv
module tile_cfg_chain #(
  parameter int unsigned        WIDTH   = 37,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= RST_VAL;
    else if (en_i) word_o <= {bit_i, word_o[WIDTH-1:1]};
  end
endmodule

// File: rtl/tile_fu.sv
module tile_fu
  import tile_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] sh;
  assign sh = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_e'(op_i))
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_SHL:  res_o = a_i << sh;
      OP_SRL:  res_o = a_i >> sh;
      OP_SLT:  res_o = {{(DATA_W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      OP_AND:  res_o = a_i & b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/tile_skid.sv
module tile_skid #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              room_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ready_i
);
  logic              skid_v;
  logic [DATA_W-1:0] skid_d;
  logic              pop;

  assign room_o = ~skid_v;
  assign pop    = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      skid_v  <= 1'b0;
      data_o  <= '0;
      skid_d  <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      skid_v  <= 1'b0;
    end else if (push_i) begin
      if (!valid_o || pop) begin
        data_o  <= data_i;
        valid_o <= 1'b1;
      end else begin
        skid_d <= data_i;
        skid_v <= 1'b1;
      end
    end else if (pop) begin
      if (skid_v) begin
        data_o <= skid_d;
        skid_v <= 1'b0;
      end else begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/overlay_tile.sv
module overlay_tile
  import tile_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_en_i,
  input  logic                          cfg_bit_i,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data_i,
  input  logic [NPORT-1:0]              in_valid_i,
  output logic [NPORT-1:0]              in_ready_o,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data_o,
  output logic [NPORT-1:0]              out_valid_o,
  input  logic [NPORT-1:0]              out_ready_i
);
  localparam int unsigned CFG_W = CTRL_W + DATA_W;
  localparam logic [CFG_W-1:0] CFG_RST =
    {{DATA_W{1'b0}}, {(NPORT+2){SRC_NONE}}, OP_ADD};

  logic [CFG_W-1:0]           cfg_q;
  logic [OP_W-1:0]            op_sel;
  logic [SEL_W-1:0]           sel_a, sel_b;
  logic [NPORT-1:0][SEL_W-1:0] osel;
  logic [DATA_W-1:0]          kval;

  logic [NPORT-1:0]              obuf_room, obuf_v, obuf_push;
  logic [NPORT-1:0][DATA_W-1:0]  obuf_din;
  logic [NPORT-1:0]              out_ok;
  logic                          fu_used, fu_room, va, vb, fu_join, fu_go;
  logic [DATA_W-1:0]             opa, opb, fu_res;

  tile_cfg_chain #(.WIDTH(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i, .rst_ni, .en_i(cfg_en_i), .bit_i(cfg_bit_i), .word_o(cfg_q)
  );

  assign op_sel = cfg_q[OP_W-1:0];
  assign sel_a  = cfg_q[OP_W +: SEL_W];
  assign sel_b  = cfg_q[OP_W+SEL_W +: SEL_W];
  assign kval   = cfg_q[CTRL_W +: DATA_W];
  for (genvar o = 0; o < NPORT; o++) begin : g_osel
    assign osel[o] = cfg_q[OP_W+2*SEL_W+o*SEL_W +: SEL_W];
  end

  // per-input readiness of the output sinks, and FU output room
  always_comb begin
    out_ok  = '1;
    fu_room = 1'b1;
    fu_used = 1'b0;
    for (int o = 0; o < NPORT; o++) begin
      if (osel[o] < SEL_W'(NPORT)) begin
        out_ok[osel[o][1:0]] = out_ok[osel[o][1:0]] & obuf_room[o];
      end else if (osel[o] == SRC_FU) begin
        fu_room = fu_room & obuf_room[o];
        fu_used = 1'b1;
      end
    end
  end

  function automatic logic opnd_valid(input logic [SEL_W-1:0] s,
                                      input logic [NPORT-1:0] v,
                                      input logic [NPORT-1:0] ok);
    if (s < SEL_W'(NPORT)) return v[s[1:0]] & ok[s[1:0]];
    return s == SRC_K;
  endfunction

  function automatic logic [DATA_W-1:0] opnd_data(input logic [SEL_W-1:0] s,
                                                  input logic [NPORT-1:0][DATA_W-1:0] d,
                                                  input logic [DATA_W-1:0] k);
    if (s < SEL_W'(NPORT)) return d[s[1:0]];
    if (s == SRC_K) return k;
    return '0;
  endfunction

  assign va      = opnd_valid(sel_a, in_valid_i, out_ok);
  assign vb      = opnd_valid(sel_b, in_valid_i, out_ok);
  assign opa     = opnd_data(sel_a, in_data_i, kval);
  assign opb     = opnd_data(sel_b, in_data_i, kval);
  assign fu_join = fu_used & fu_room & va & vb;
  assign fu_go   = fu_join & ~cfg_en_i;

  tile_fu #(.DATA_W(DATA_W)) u_fu (
    .op_i(op_sel), .a_i(opa), .b_i(opb), .res_o(fu_res)
  );

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      logic used, by_fu;
      by_fu = (sel_a == SEL_W'(i)) || (sel_b == SEL_W'(i));
      used  = by_fu;
      for (int o = 0; o < NPORT; o++) used = used | (osel[o] == SEL_W'(i));
      in_ready_o[i] = used & out_ok[i] & (by_fu ? fu_join : 1'b1) & ~cfg_en_i;
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      obuf_push[o] = 1'b0;
      obuf_din[o]  = '0;
      if (osel[o] < SEL_W'(NPORT)) begin
        obuf_push[o] = in_valid_i[osel[o][1:0]] & in_ready_o[osel[o][1:0]];
        obuf_din[o]  = in_data_i[osel[o][1:0]];
      end else if (osel[o] == SRC_FU) begin
        obuf_push[o] = fu_go;
        obuf_din[o]  = fu_res;
      end else if (osel[o] == SRC_K) begin
        obuf_push[o] = obuf_room[o] & ~cfg_en_i;
        obuf_din[o]  = kval;
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    tile_skid #(.DATA_W(DATA_W)) u_skid (
      .clk_i, .rst_ni, .flush_i(cfg_en_i),
      .push_i(obuf_push[o]), .data_i(obuf_din[o]), .room_o(obuf_room[o]),
      .valid_o(obuf_v[o]), .data_o(out_data_o[o]), .ready_i(out_ready_i[o])
    );
  end

  assign out_valid_o = obuf_v & ~{NPORT{cfg_en_i}};
endmodule

// File: rtl/tile_chk.sv
module tile_chk
  import tile_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cfg_en_i,
  input logic [NPORT-1:0]              in_valid_i,
  input logic [NPORT-1:0]              in_ready_o,
  input logic [NPORT-1:0][DATA_W-1:0]  out_data_o,
  input logic [NPORT-1:0]              out_valid_o,
  input logic [NPORT-1:0]              out_ready_i,
  input logic [NPORT-1:0][SEL_W-1:0]   osel,
  input logic [SEL_W-1:0]              sel_a,
  input logic [SEL_W-1:0]              sel_b,
  input logic [NPORT-1:0]              obuf_room
);
  p_cfg_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (out_valid_o == '0) && (in_ready_o == '0));

  p_fu_join_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a < SEL_W'(NPORT)) && (sel_b < SEL_W'(NPORT))
    |-> in_ready_o[sel_a[1:0]] == in_ready_o[sel_b[1:0]]);

  for (genvar o = 0; o < NPORT; o++) begin : g_port
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] && !out_ready_i[o]
      |=> cfg_en_i || (out_valid_o[o] && $stable(out_data_o[o])));

    p_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osel[o] >= SRC_NONE) |-> !out_valid_o[o]);

    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (osel[o] < SEL_W'(NPORT)) && in_valid_i[osel[o][1:0]] && in_ready_o[osel[o][1:0]]
      |-> obuf_room[o]);
  end
endmodule

bind overlay_tile tile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .osel(osel), .sel_a(sel_a), .sel_b(sel_b), .obuf_room(obuf_room)
);

// File: tb/sim_overlay_tile.sv
module sim_overlay_tile;
  localparam int W  = 16;
  localparam int CW = 21 + W;
  localparam logic [2:0] N = 0, E = 1, S = 2, WS = 3, FU = 4, K = 5, NO = 6;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_bit = 0;
  logic [3:0][W-1:0] in_data = '0, out_data;
  logic [3:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  overlay_tile #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  // {op, a, b, expected}
  localparam logic [50:0] VEC [13] = '{
    {3'd0, 16'h1234, 16'h0F0F, 16'h2143},
    {3'd0, 16'hFFFF, 16'h0002, 16'h0001},
    {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
    {3'd2, 16'h0300, 16'h0101, 16'h0300},
    {3'd2, 16'h0007, 16'h0006, 16'h002A},
    {3'd3, 16'h0001, 16'h0004, 16'h0010},
    {3'd3, 16'h8001, 16'h0011, 16'h0002},
    {3'd4, 16'h8000, 16'h000F, 16'h0001},
    {3'd5, 16'hFFFF, 16'h0001, 16'h0001},
    {3'd5, 16'h0001, 16'hFFFF, 16'h0000},
    {3'd5, 16'h0003, 16'h0003, 16'h0000},
    {3'd6, 16'hF0F0, 16'h3C3C, 16'h3030},
    {3'd7, 16'hABCD, 16'h1111, 16'hABCD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input logic [2:0] op, sa, sb, sn, se, ss, sw,
                                       input logic [W-1:0] k);
    return {k, sw, ss, se, sn, sb, sa, op};
  endfunction

  // R11: LSB first while enable high; R8 checked mid-load
  task automatic load(input logic [CW-1:0] w);
    @(negedge clk);
    cfg_en = 1;
    for (int i = 0; i < CW; i++) begin
      cfg_bit = w[i];
      if (i == 3) begin
        #1;
        chk("R8 valid", {28'd0, out_valid}, 32'd0);
        chk("R8 ready", {28'd0, in_ready}, 32'd0);
      end
      @(negedge clk);
    end
    cfg_en = 0;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 4'hF;
    #20;
    chk("R1 valid", {28'd0, out_valid}, 32'd0);
    chk("R1 ready", {28'd0, in_ready}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R1/R9 ready none", {28'd0, in_ready}, 32'd0);
    chk("R1/R9 valid none", {28'd0, out_valid}, 32'd0);
    in_valid = 0;

    // R2 operation table
    for (int v = 0; v < 13; v++) begin
      load(mk(VEC[v][50:48], N, WS, NO, FU, NO, NO, '0));
      in_data[0] = VEC[v][47:32]; in_data[3] = VEC[v][31:16];
      in_valid = 4'b1001; out_ready = 4'b0010;
      #1 chk("R3 both taken", {28'd0, in_ready}, 32'h9);
      @(negedge clk); in_valid = 0; #1;
      chk("R2 valid", {31'd0, out_valid[1]}, 32'd1);
      chk("R2 result", {16'd0, out_data[1]}, {16'd0, VEC[v][15:0]});
    end

    // R3 join and stall
    load(mk(3'd0, N, WS, NO, FU, NO, NO, '0));
    out_ready = 0; in_data[0] = 16'd10; in_data[3] = 16'd1; in_valid = 4'b0001;
    #1 chk("R3 lone operand not taken", {28'd0, in_ready}, 32'd0);
    @(negedge clk); #1 chk("R3 no fire", {31'd0, out_valid[1]}, 32'd0);
    in_valid = 4'b1001;
    #1 chk("R3 join", {28'd0, in_ready}, 32'h9);
    @(negedge clk); in_data[3] = 16'd2;
    #1 chk("R3 second", {28'd0, in_ready}, 32'h9);
    @(negedge clk); in_data[3] = 16'd3;
    #1 chk("R3 stall when full", {28'd0, in_ready}, 32'd0);
    chk("R6 held", {16'd0, out_data[1]}, 32'd11);
    in_valid = 0; out_ready = 4'b0010;
    @(negedge clk); #1 chk("R7 order FU", {16'd0, out_data[1]}, 32'd12);

    // R4 pass-through
    load(mk(3'd0, NO, NO, NO, WS, N, NO, '0));
    in_data[0] = 16'h1111; in_data[3] = 16'h2222; in_valid = 4'b1001; out_ready = 4'hF;
    @(negedge clk); in_valid = 0; #1;
    chk("R4 S valid", {28'd0, out_valid}, 32'h6);
    chk("R4 S data", {16'd0, out_data[2]}, 32'h1111);
    chk("R4 E data", {16'd0, out_data[1]}, 32'h2222);

    // R7 skid depth and order
    load(mk(3'd0, NO, NO, NO, NO, N, NO, '0));
    out_ready = 0; in_valid = 4'b0001; in_data[0] = 16'd1;
    @(negedge clk); in_data[0] = 16'd2;
    #1 chk("R7 room second", {31'd0, in_ready[0]}, 32'd1);
    @(negedge clk); in_data[0] = 16'd3;
    #1 chk("R7 full", {31'd0, in_ready[0]}, 32'd0);
    in_valid = 0; out_ready = 4'b0100;
    chk("R7 first", {16'd0, out_data[2]}, 32'd1);
    @(negedge clk); #1 chk("R7 second", {16'd0, out_data[2]}, 32'd2);
    @(negedge clk); #1 chk("R7 drained", {31'd0, out_valid[2]}, 32'd0);

    // R10 fork N -> E and S, E stalled
    load(mk(3'd0, NO, NO, NO, N, N, NO, '0));
    out_ready = 4'b0100; in_valid = 4'b0001; in_data[0] = 16'd7;
    @(negedge clk); in_data[0] = 16'd8;
    @(negedge clk); in_data[0] = 16'd9;
    #1 chk("R10 fork stall", {31'd0, in_ready[0]}, 32'd0);
    chk("R10 S got second", {16'd0, out_data[2]}, 32'd8);
    chk("R10 E held first", {16'd0, out_data[1]}, 32'd7);
    in_valid = 0;

    // R5 constant
    load(mk(3'd0, NO, NO, NO, NO, NO, K, 16'h5A5A));
    out_ready = 4'b1000;
    @(negedge clk); #1;
    chk("R5 valid", {31'd0, out_valid[3]}, 32'd1);
    chk("R5 data", {16'd0, out_data[3]}, 32'h5A5A);
    chk("R9 others idle", {29'd0, out_valid[2:0]}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule